// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks divider settings for a clock synthesizer whose VCO runs at ref × (n+1) / (m+1) and whose output is the VCO divided by (p+1). On a start pulse it takes a requested output frequency in kHz. It takes a reference frequency in hundredths of a kHz, so that values such as 14,318.18 kHz and 27,050.5 kHz are exact. It also takes the allowed ranges of the input divider m and the feedback divider n.

The engine first chooses the post divider from the doubling sequence 0, 1, 3, 7, which sets a target VCO frequency. It then walks every (m, n) pair in the given ranges. Each candidate frequency goes through a bit-serial restoring divider, and the engine keeps the pair closest to the target. At the end it derives a loop filter band code from the chosen VCO frequency. It reports three packed register bytes and the achieved output frequency, together with a one-cycle done pulse.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy_o and done_o are 0, and m_byte_o, n_byte_o, ps_byte_o and fout_o are all 0.
- R2: A requested frequency below 6,250 kHz is treated as 6,250 kHz. This clamped value is called F.
- R3: The post divider p is 0 if F ≥ 50,000. It is 1 if F ≥ 25,000, 3 if F ≥ 12,500, and 7 otherwise. The target VCO frequency T is F × (p+1) kHz.
- R4: A candidate frequency Q, in 0.01 kHz units, is floor(ref × (n+1) / (m+1)). Its error is |Q − 100·T|.
- R5: Candidates are visited with m as the outer loop and n as the inner loop, both in ascending order. A candidate becomes the best only when its error is strictly smaller than the best error so far, so on a tie the first pair visited wins.
- R6: The best error starts at 100·F. If no candidate beats it, the result is the first pair (m_min, n_min) with its own Q.
- R7: The band code s is computed from the best Q. It is 0 if Q < 10,000,000, 1 if Q < 14,000,000, 2 if Q < 18,000,000, and 3 otherwise.
- R8: m_byte_o = m & 0x1F and n_byte_o = n & 0x7F. In ps_byte_o, p sits in bits 2:0, s sits in bits 4:3, and bits 7:5 are 0.
- R9: fout_o = floor(best Q / (p+1)), in 0.01 kHz units.
- R10: done_o is high for exactly one cycle, when busy_o is already low. The result outputs change only on the done cycle. busy_o rises only after a start. While busy, start_i and changes on the configuration inputs have no effect.
- R11: With default parameters, done_o is visible 34·C + 1 clock edges after the edge that samples start_i. Here C = (m_max − m_min + 1)(n_max − n_min + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (sampled while idle) |
| target_khz_i | input | 20 | Requested output frequency, kHz |
| ref_i | input | 24 | Reference frequency, 0.01 kHz units |
| m_min_i | input | 5 | Lowest input divider value |
| m_max_i | input | 5 | Highest input divider value |
| n_min_i | input | 7 | Lowest feedback divider value |
| n_max_i | input | 7 | Highest feedback divider value |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| m_byte_o | output | 8 | Packed input divider byte |
| n_byte_o | output | 8 | Packed feedback divider byte |
| ps_byte_o | output | 8 | Packed post divider and band code byte |
| fout_o | output | 32 | Achieved output frequency, 0.01 kHz units |

## Verification
Faults in the internal state appear at the ports in different ways:

- A fault in the divider or in the error comparison shows up as a wrong pair, a wrong band code or a wrong fout_o on the very next done strobe.
- A fault in the candidate walk shows up as a latency that differs from 34·C + 1 edges.
- Configuration that is not held through the search shows up as a different result when start_i and the range inputs are disturbed mid-search.
- Ties and the no-winner case expose the comparison rule and the default pair directly in m_byte_o and n_byte_o.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_KICK, ST_WAIT, ST_FIN} srch_st_e;

  localparam int unsigned VCO_MIN_KHZ = 50000;
  localparam int unsigned F_FLOOR_KHZ = VCO_MIN_KHZ / 8;

  function automatic logic [1:0] p_to_shift(input logic [2:0] p);
    case (p)
      3'd0:    return 2'd0;
      3'd1:    return 2'd1;
      3'd3:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/pll_post_sel.sv
module pll_post_sel import pll_search_pkg::*; #(
  parameter int FKHZ_W = 20
) (
  input  logic [FKHZ_W-1:0] f_khz_i,
  output logic [FKHZ_W-1:0] f_clamp_o,
  output logic [2:0]        p_o,
  output logic [FKHZ_W+2:0] vco_khz_o
);
  localparam int VW = FKHZ_W + 3;
  logic [VW-1:0] f_w;

  always_comb begin
    f_clamp_o = (f_khz_i < FKHZ_W'(F_FLOOR_KHZ)) ? FKHZ_W'(F_FLOOR_KHZ) : f_khz_i;
    f_w = VW'(f_clamp_o);
    if (f_w >= VW'(VCO_MIN_KHZ))          p_o = 3'd0;
    else if (f_w >= VW'(VCO_MIN_KHZ / 2)) p_o = 3'd1;
    else if (f_w >= VW'(VCO_MIN_KHZ / 4)) p_o = 3'd3;
    else                                  p_o = 3'd7;
    vco_khz_o = f_w << p_to_shift(p_o);
  end
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   trial;
  logic             ge;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    ge    = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        quo_q <= num_i;
        den_q <= den_i;
        rem_q <= '0;
        cnt_q <= CNT_W'(NUM_W - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        quo_q <= {quo_q[NUM_W-2:0], ge};
        rem_q <= ge ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/pll_band_enc.sv
module pll_band_enc #(
  parameter int QW = 32
) (
  input  logic [QW-1:0] vco_i,
  output logic [1:0]    s_o
);
  // band edges in 0.01 kHz
  localparam logic [QW-1:0] EDGE0 = QW'(10_000_000);
  localparam logic [QW-1:0] EDGE1 = QW'(14_000_000);
  localparam logic [QW-1:0] EDGE2 = QW'(18_000_000);

  always_comb begin
    if (vco_i < EDGE0)      s_o = 2'd0;
    else if (vco_i < EDGE1) s_o = 2'd1;
    else if (vco_i < EDGE2) s_o = 2'd2;
    else                    s_o = 2'd3;
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search import pll_search_pkg::*; #(
  parameter int FKHZ_W = 20,
  parameter int REF_W  = 24,
  parameter int M_W    = 5,
  parameter int N_W    = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [FKHZ_W-1:0]            target_khz_i,
  input  logic [REF_W-1:0]             ref_i,
  input  logic [M_W-1:0]               m_min_i,
  input  logic [M_W-1:0]               m_max_i,
  input  logic [N_W-1:0]               n_min_i,
  input  logic [N_W-1:0]               n_max_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [7:0]                   m_byte_o,
  output logic [7:0]                   n_byte_o,
  output logic [7:0]                   ps_byte_o,
  output logic [REF_W+N_W:0]           fout_o
);
  localparam int NUM_W = REF_W + N_W + 1;
  localparam int DEN_W = M_W + 1;
  localparam int QW    = NUM_W;
  localparam int ERR_W = QW;

  srch_st_e st_q;
  logic [REF_W-1:0]  ref_q;
  logic [M_W-1:0]    m_q, m_max_q, best_m_q;
  logic [N_W-1:0]    n_q, n_min_q, n_max_q, best_n_q;
  logic [2:0]        p_q;
  logic [ERR_W-1:0]  t100_q, berr_q, err;
  logic [QW-1:0]     best_q_q, quo;
  logic              first_q, done_q, better, div_done;
  logic [FKHZ_W-1:0] f_cl;
  logic [2:0]        p_sel;
  logic [FKHZ_W+2:0] vco_sel;
  logic [NUM_W-1:0]  num;
  logic [DEN_W-1:0]  den;
  logic [1:0]        s_code;

  pll_post_sel #(.FKHZ_W(FKHZ_W)) u_post (
    .f_khz_i(target_khz_i), .f_clamp_o(f_cl), .p_o(p_sel), .vco_khz_o(vco_sel)
  );

  assign num = NUM_W'(ref_q) * NUM_W'({1'b0, n_q} + 1'b1);
  assign den = {1'b0, m_q} + 1'b1;

  pll_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i, .rst_ni, .start_i(st_q == ST_KICK), .num_i(num), .den_i(den),
    .done_o(div_done), .quo_o(quo)
  );

  pll_band_enc #(.QW(QW)) u_band (.vco_i(best_q_q), .s_o(s_code));

  always_comb begin
    err    = (quo >= t100_q) ? quo - t100_q : t100_q - quo;
    better = err < berr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ref_q     <= '0;
      m_q       <= '0;
      m_max_q   <= '0;
      n_q       <= '0;
      n_min_q   <= '0;
      n_max_q   <= '0;
      best_m_q  <= '0;
      best_n_q  <= '0;
      best_q_q  <= '0;
      p_q       <= '0;
      t100_q    <= '0;
      berr_q    <= '0;
      first_q   <= 1'b0;
      done_q    <= 1'b0;
      m_byte_o  <= '0;
      n_byte_o  <= '0;
      ps_byte_o <= '0;
      fout_o    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          ref_q   <= ref_i;
          m_q     <= m_min_i;
          m_max_q <= m_max_i;
          n_q     <= n_min_i;
          n_min_q <= n_min_i;
          n_max_q <= n_max_i;
          p_q     <= p_sel;
          t100_q  <= ERR_W'(vco_sel) * ERR_W'(100);
          berr_q  <= ERR_W'(f_cl) * ERR_W'(100);
          first_q <= 1'b1;
          st_q    <= ST_KICK;
        end
        ST_KICK: st_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          // first pair is the default result even when it does not win
          if (better || first_q) begin
            best_m_q <= m_q;
            best_n_q <= n_q;
            best_q_q <= quo;
          end
          if (better) berr_q <= err;
          first_q <= 1'b0;
          if (n_q != n_max_q) begin
            n_q  <= n_q + 1'b1;
            st_q <= ST_KICK;
          end else if (m_q != m_max_q) begin
            m_q  <= m_q + 1'b1;
            n_q  <= n_min_q;
            st_q <= ST_KICK;
          end else begin
            st_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          m_byte_o  <= 8'(best_m_q) & 8'h1F;
          n_byte_o  <= 8'(best_n_q) & 8'h7F;
          ps_byte_o <= {3'b000, s_code, p_q};
          fout_o    <= best_q_q >> p_to_shift(p_q);
          done_q    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] m_byte_o,
  input logic [7:0] n_byte_o,
  input logic [7:0] ps_byte_o
);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(m_byte_o) && $stable(n_byte_o) && $stable(ps_byte_o)));

  a_r10_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r8_pack_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (m_byte_o[7:5] == 3'b0 && n_byte_o[7] == 1'b0 && ps_byte_o[7:5] == 3'b0));

  a_r3_p_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ps_byte_o[2:0] == 3'd0 || ps_byte_o[2:0] == 3'd1 ||
                ps_byte_o[2:0] == 3'd3 || ps_byte_o[2:0] == 3'd7));
endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .m_byte_o(m_byte_o), .n_byte_o(n_byte_o), .ps_byte_o(ps_byte_o)
);

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] target_khz_i = '0;
  logic [23:0] ref_i = '0;
  logic [4:0]  m_min_i = '0, m_max_i = '0;
  logic [6:0]  n_min_i = '0, n_max_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  m_byte_o, n_byte_o, ps_byte_o;
  logic [31:0] fout_o;

  int checks = 0;
  int errors = 0;
  bit wd_hit = 1'b0;

  always #5 clk_i = ~clk_i;

  pll_div_search u_pll_div_search (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic model(input longint tgt, input longint rf, input longint mlo, input longint mhi,
                       input longint nlo, input longint nhi,
                       output longint em, output longint en, output longint eps, output longint efo);
    longint f, p, v, berr, bq, q, e, s;
    f = (tgt < 6250) ? 6250 : tgt;                       // R2
    p = 0; v = f;
    while (p <= 7 && v < 50000) begin p = p * 2 + 1; v = v * 2; end  // R3
    berr = f * 100;                                      // R6
    em = mlo; en = nlo; bq = rf * (nlo + 1) / (mlo + 1);
    for (longint m = mlo; m <= mhi; m++)
      for (longint n = nlo; n <= nhi; n++) begin
        q = rf * (n + 1) / (m + 1);                      // R4
        e = (q >= v * 100) ? q - v * 100 : v * 100 - q;
        if (e < berr) begin berr = e; em = m; en = n; bq = q; end  // R5
      end
    s = (bq < 10000000) ? 0 : (bq < 14000000) ? 1 : (bq < 18000000) ? 2 : 3;  // R7
    eps = p | (s << 3);                                  // R8
    efo = bq / (p + 1);                                  // R9
  endtask

  task automatic run_case(input longint tgt, input longint rf, input longint mlo, input longint mhi,
                          input longint nlo, input longint nhi, input bit disturb);
    longint em, en, eps, efo, lat, cands;
    model(tgt, rf, mlo, mhi, nlo, nhi, em, en, eps, efo);
    cands = (mhi - mlo + 1) * (nhi - nlo + 1);
    @(negedge clk_i);
    target_khz_i = 20'(tgt); ref_i = 24'(rf);
    m_min_i = 5'(mlo); m_max_i = 5'(mhi); n_min_i = 7'(nlo); n_max_i = 7'(nhi);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && !wd_hit) begin
      if (disturb && lat == 40) begin
        start_i = 1'b1; target_khz_i = 20'd777; ref_i = 24'd3000000;
        m_max_i = 5'd31; n_min_i = 7'd1; n_max_i = 7'd2;
      end else start_i = 1'b0;
      @(posedge clk_i); lat++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk("R5 m_byte", m_byte_o, em & 'h1F);
    chk("R5 n_byte", n_byte_o, en & 'h7F);
    chk("R8 ps_byte", ps_byte_o, eps);
    chk("R9 fout", fout_o, efo);
    chk("R11 latency", lat, 34 * cands + 1);
    chk("R10 busy low at done", busy_o, 0);
    @(negedge clk_i);
    chk("R10 done pulse width", done_o, 0);
    chk("R10 result hold", m_byte_o, em & 'h1F);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    wd_hit = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog expired");
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 busy reset", busy_o, 0);
    chk("R1 done reset", done_o, 0);
    chk("R1 m_byte reset", m_byte_o, 0);
    chk("R1 ps_byte reset", ps_byte_o, 0);
    chk("R1 fout reset", fout_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R5 tie: (1,15), (2,23) and (3,31) all exact, first wins
    run_case(80000, 1000000, 1, 3, 15, 31, 0);
    chk("R5 tie earliest m", m_byte_o, 1);
    chk("R5 tie earliest n", n_byte_o, 15);
    // R6 nothing beats the initial error: first pair reported
    run_case(7000, 1000000, 1, 1, 100, 101, 0);
    chk("R6 default pair n", n_byte_o, 100);
    // R2 floor: 100 kHz behaves like 6250 kHz, p=7
    run_case(100, 1431818, 1, 6, 7, 20, 0);
    chk("R2 floor p", ps_byte_o & 7, 7);
    // R3 thresholds at the edges
    run_case(50000, 2705050, 1, 3, 7, 15, 0);
    chk("R3 p at 50000", ps_byte_o & 7, 0);
    run_case(49999, 2705050, 1, 3, 7, 15, 0);
    chk("R3 p at 49999", ps_byte_o & 7, 1);
    run_case(12500, 2705050, 1, 2, 7, 12, 0);
    chk("R3 p at 12500", ps_byte_o & 7, 3);
    // R7 high band
    run_case(200000, 1431818, 1, 2, 20, 40, 0);
    // R10 start and config changes ignored while busy
    run_case(135000, 2705050, 2, 4, 30, 45, 1);
    // wide range
    run_case(65000, 2705050, 1, 6, 7, 127, 0);
    for (int i = 0; i < 20 && !wd_hit; i++) begin
      longint rf, mlo, nlo;
      case ($urandom_range(2))
        0: rf = 1431818;
        1: rf = 2705050;
        default: rf = 1000000 + $urandom_range(2000000);
      endcase
      mlo = 1 + $urandom_range(3);
      nlo = 7 + $urandom_range(90);
      run_case(1000 + $urandom_range(400000), rf, mlo, mlo + $urandom_range(3),
               nlo, nlo + $urandom_range(20), i % 5 == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule